// File: doc/BRIEF.md
# PCIe Configuration Load Sequencer

This block drives the host side of loading an FPGA image over PCIe configuration access. A small dword register master (request and acknowledge, address, write data, read data) reaches a vendor-specific capability window that holds five registers: status, mode, data, program control and an uncorrectable-error register. A 32-bit image stream with valid, ready and last flags supplies the payload. The sequencer runs the whole bring-up, data phase and teardown as a fixed, ordered chain of register reads and writes. It then reports completion on `done_o` and a result code on `err_o`.

A load begins with a pulse on `start_i`, with `compressed_i` and `encrypted_i` describing the image. The sequencer first reads status (`S_STAT_RD`). If the enable flag is missing it fails. If a previous load left config-ready set, it runs a teardown first. It then enters configuration mode in two separate read-modify-writes (`S_MODE_RD_CLK`/`S_MODE_WR_CLK`, then `S_MODE_RD_CFG`/`S_MODE_WR_CFG`). It requests configuration (`S_PROG_RD_CFG`/`S_PROG_WR_CFG`) and polls for ready (`S_POLL_RD`/`S_POLL_WAIT`). It then starts the transfer (`S_PROG_RD_XFER`/`S_PROG_WR_XFER`) and loads the clock-to-data ratio (`S_MODE_RD_RATIO`/`S_MODE_WR_RATIO`). Next it streams the image (`S_DATA_WAIT`/`S_DATA_WR`) and tears down (`S_TD_RD`, `S_TD_WR_XFER`, `S_TD_WR_CFG`). After that it reads the latched error (`S_ERR_RD`), leaves configuration mode (`S_MODE_RD_EXIT`/`S_MODE_WR_EXIT`) and polls for user mode. Each clock switch (`S_CS_RD`, `S_CS_WR`, `S_CS_DUMMY`) returns to the step recorded when it was entered. Every terminal branch returns to `S_IDLE` with a one-cycle `done_o`.

Register offsets: status 0x1C, mode 0x20, data 0x28, program control 0x2C, uncorrectable error 0x34.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `reg_req_o` and `img_ready_o` are 0 and `err_o` is 0.
- R2: If status bit 20 (enable) reads 0 at start, the load ends with `err_o` = 1 and no register write is issued.
- R3: If status bit 18 (config-ready) reads 1 at start, a teardown runs before mode entry. The teardown clears program bit 1, then clears program bit 0, then runs a clock switch and waits for ready = 0. Only then does the normal load begin.
- R4: Mode entry sets mode bit 1 (transceiver clock) in one read-modify-write, then sets mode bit 0 (config mode) in a second one. Every other mode bit is preserved.
- R5: A clock switch writes mode bits 15:8 = 1, keeping the other bits, and then issues exactly DUMMY_WRITES writes to the data register. It runs after mode entry, after ready rises, and during each teardown.
- R6: Each poll reads status at most ceil(timeout/interval) times. A ready poll that never matches ends with `err_o` = 2.
- R7: After program bit 1 is set, mode bits 15:8 are written with 8 for a compressed image, 4 for an encrypted uncompressed image, and 1 otherwise.
- R8: Image words are written to the data register in stream order, each exactly once. `img_ready_o` is high only while no register access is pending. The word flagged last ends the data phase.
- R9: After the data phase, the teardown writes program control with bit 1 cleared and then with bits 1 and 0 cleared. It then runs a clock switch and polls ready = 0.
- R10: If bit 5 of the uncorrectable-error register (0x34) is set after teardown, the load ends with `err_o` = 3 and mode is not written again.
- R11: Otherwise one write clears mode bits 1:0 together and the block polls until status bits 21 and 24 are both set. On success it ends with `err_o` = 0; on timeout it ends with `err_o` = 4.
- R12: Two consecutive status reads of one poll are at least CLK_MHZ*IVL_US clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (ignored while busy) |
| compressed_i | input | 1 | Image is compressed |
| encrypted_i | input | 1 | Image is encrypted |
| img_data_i | input | 32 | Image word |
| img_valid_i | input | 1 | Image word valid |
| img_last_i | input | 1 | Image word is the final one |
| img_ready_o | output | 1 | Sequencer accepts an image word |
| reg_req_o | output | 1 | Register access request, held until acknowledged |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 8 | Register offset in the capability window |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | One-cycle access completion |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a load ends |
| err_o | output | 3 | Result: 0 ok, 1 not enabled, 2 ready timeout, 3 latched error, 4 user-mode timeout |

## Verification
The hardest state to reach from the ports is the teardown that runs before the normal load. It needs config-ready to read 1 before the block has written anything. The bench's register model is preloaded with program control already holding both request bits, so its ready flag, which follows the config request bit, is high at the first status read. Timeouts and the latched error come from model knobs that pin ready low, withhold user mode or set bit 5. The exact control-write order is compared with a list built by a bench function, and so is the data-write count between control writes.

// File: rtl/cls_pkg.sv
package cls_pkg;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] A_STAT = 8'h1C;
    localparam logic [AW-1:0] A_MODE = 8'h20;
    localparam logic [AW-1:0] A_DATA = 8'h28;
    localparam logic [AW-1:0] A_PROG = 8'h2C;
    localparam logic [AW-1:0] A_UERR = 8'h34;

    localparam int unsigned ST_RDY   = 18;
    localparam int unsigned ST_EN    = 20;
    localparam int unsigned ST_USER  = 21;
    localparam int unsigned ST_FCLK  = 24;
    localparam int unsigned MD_CFG   = 0;
    localparam int unsigned MD_XCVR  = 1;
    localparam int unsigned MD_RLO   = 8;
    localparam int unsigned PG_CFG   = 0;
    localparam int unsigned PG_XFER  = 1;
    localparam int unsigned UE_LATCH = 5;

    typedef enum logic [2:0] {
        E_NONE = 3'd0, E_ABSENT = 3'd1, E_RDY_TO = 3'd2,
        E_LATCHED = 3'd3, E_USER_TO = 3'd4
    } err_e;

    typedef enum logic [1:0] {PK_RDY_HI, PK_RDY_LO, PK_USER} poll_e;
    typedef enum logic [1:0] {CR_CFG, CR_XFER, CR_TD} csret_e;

    typedef enum logic [4:0] {
        S_IDLE, S_STAT_RD,
        S_MODE_RD_CLK, S_MODE_WR_CLK, S_MODE_RD_CFG, S_MODE_WR_CFG,
        S_CS_RD, S_CS_WR, S_CS_DUMMY,
        S_PROG_RD_CFG, S_PROG_WR_CFG, S_POLL_RD, S_POLL_WAIT,
        S_PROG_RD_XFER, S_PROG_WR_XFER, S_MODE_RD_RATIO, S_MODE_WR_RATIO,
        S_DATA_WAIT, S_DATA_WR,
        S_TD_RD, S_TD_WR_XFER, S_TD_WR_CFG,
        S_ERR_RD, S_MODE_RD_EXIT, S_MODE_WR_EXIT
    } state_e;
endpackage

// File: rtl/cls_poll_timer.sv
module cls_poll_timer #(
    parameter int unsigned IVL_CYC = 1000,
    parameter int unsigned TRY_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             miss_i,
    input  logic [TRY_W-1:0] limit_i,
    output logic             last_o,
    output logic             wait_done_o
);
    localparam int unsigned IW = $clog2(IVL_CYC + 1);
    localparam logic [IW-1:0] IVL_RELOAD = IW'(IVL_CYC - 1);

    logic [TRY_W-1:0] misses_q;
    logic [IW-1:0]    ivl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misses_q <= '0;
            ivl_q    <= '0;
        end else if (clr_i) begin
            misses_q <= '0;
            ivl_q    <= '0;
        end else if (miss_i) begin
            misses_q <= misses_q + 1'b1;
            ivl_q    <= IVL_RELOAD;
        end else if (ivl_q != '0) begin
            ivl_q <= ivl_q - 1'b1;
        end
    end

    assign last_o      = (misses_q == limit_i - 1'b1);
    assign wait_done_o = (ivl_q == '0);

    generate
        if (IVL_CYC > 1) begin : g_gap_chk
            // R12: a failed read always restarts a full wait interval
            p_wait_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (miss_i && !clr_i) |=> !wait_done_o);
        end
    endgenerate
endmodule

// File: rtl/cls_burst.sv
module cls_burst #(
    parameter int unsigned COUNT = 244
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(COUNT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= CW'(COUNT);
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == CW'(1));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cls_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned IVL_US       = 10,
    parameter int unsigned RDY_TO_US    = 10,
    parameter int unsigned USER_TO_US   = 2000,
    parameter int unsigned DUMMY_WRITES = 244
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          compressed_i,
    input  logic          encrypted_i,
    input  logic [31:0]   img_data_i,
    input  logic          img_valid_i,
    input  logic          img_last_i,
    output logic          img_ready_o,
    output logic          reg_req_o,
    output logic          reg_we_o,
    output logic [7:0]    reg_addr_o,
    output logic [31:0]   reg_wdata_o,
    input  logic [31:0]   reg_rdata_i,
    input  logic          reg_ack_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [2:0]    err_o
);
    localparam int unsigned IVL_CYC    = CLK_MHZ * IVL_US;
    localparam int unsigned RDY_TRIES  = (RDY_TO_US + IVL_US - 1) / IVL_US;
    localparam int unsigned USER_TRIES = (USER_TO_US + IVL_US - 1) / IVL_US;
    localparam int unsigned RDY_LIM    = (RDY_TRIES < 1) ? 1 : RDY_TRIES;
    localparam int unsigned USER_LIM   = (USER_TRIES < 1) ? 1 : USER_TRIES;
    localparam int unsigned TRY_MAX    = (RDY_LIM > USER_LIM) ? RDY_LIM : USER_LIM;
    localparam int unsigned TRY_W      = $clog2(TRY_MAX + 1);

    state_e      state_q;
    err_e        err_q;
    poll_e       poll_q;
    csret_e      ret_q;
    logic [31:0] rd_q, img_q;
    logic [7:0]  ratio_q;
    logic        last_q, pre_q, done_q;

    logic             polling, poll_hit, miss, try_last, wait_done, burst_last;
    logic [TRY_W-1:0] limit;

    assign polling = (state_q == S_POLL_RD) || (state_q == S_POLL_WAIT);
    assign limit   = (poll_q == PK_USER) ? TRY_W'(USER_LIM) : TRY_W'(RDY_LIM);

    always_comb begin
        unique case (poll_q)
            PK_RDY_HI: poll_hit = reg_rdata_i[ST_RDY];
            PK_RDY_LO: poll_hit = !reg_rdata_i[ST_RDY];
            default:   poll_hit = reg_rdata_i[ST_USER] && reg_rdata_i[ST_FCLK];
        endcase
    end
    assign miss = (state_q == S_POLL_RD) && reg_ack_i && !poll_hit;

    cls_poll_timer #(.IVL_CYC(IVL_CYC), .TRY_W(TRY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(!polling), .miss_i(miss),
        .limit_i(limit), .last_o(try_last), .wait_done_o(wait_done)
    );

    cls_burst #(.COUNT(DUMMY_WRITES)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .load_i((state_q == S_CS_WR) && reg_ack_i),
        .dec_i((state_q == S_CS_DUMMY) && reg_ack_i),
        .last_o(burst_last)
    );

    // State register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= E_NONE;
            poll_q  <= PK_RDY_HI;
            ret_q   <= CR_CFG;
            rd_q    <= '0;
            img_q   <= '0;
            ratio_q <= 8'd1;
            last_q  <= 1'b0;
            pre_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (reg_ack_i && !reg_we_o) rd_q <= reg_rdata_i;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    err_q   <= E_NONE;
                    pre_q   <= 1'b0;
                    ratio_q <= compressed_i ? 8'd8 : (encrypted_i ? 8'd4 : 8'd1);
                    state_q <= S_STAT_RD;
                end
                S_STAT_RD: if (reg_ack_i) begin
                    if (!reg_rdata_i[ST_EN]) begin
                        err_q <= E_ABSENT; done_q <= 1'b1; state_q <= S_IDLE;
                    end else if (reg_rdata_i[ST_RDY]) begin
                        pre_q <= 1'b1; state_q <= S_TD_RD;
                    end else state_q <= S_MODE_RD_CLK;
                end
                S_MODE_RD_CLK:  if (reg_ack_i) state_q <= S_MODE_WR_CLK;
                S_MODE_WR_CLK:  if (reg_ack_i) state_q <= S_MODE_RD_CFG;
                S_MODE_RD_CFG:  if (reg_ack_i) state_q <= S_MODE_WR_CFG;
                S_MODE_WR_CFG:  if (reg_ack_i) begin ret_q <= CR_CFG; state_q <= S_CS_RD; end
                S_CS_RD:        if (reg_ack_i) state_q <= S_CS_WR;
                S_CS_WR:        if (reg_ack_i) state_q <= S_CS_DUMMY;
                S_CS_DUMMY: if (reg_ack_i && burst_last) begin
                    unique case (ret_q)
                        CR_CFG:  state_q <= S_PROG_RD_CFG;
                        CR_XFER: state_q <= S_PROG_RD_XFER;
                        default: begin poll_q <= PK_RDY_LO; state_q <= S_POLL_RD; end
                    endcase
                end
                S_PROG_RD_CFG:  if (reg_ack_i) state_q <= S_PROG_WR_CFG;
                S_PROG_WR_CFG:  if (reg_ack_i) begin poll_q <= PK_RDY_HI; state_q <= S_POLL_RD; end
                S_POLL_RD: if (reg_ack_i) begin
                    if (poll_hit) begin
                        unique case (poll_q)
                            PK_RDY_HI: begin ret_q <= CR_XFER; state_q <= S_CS_RD; end
                            PK_RDY_LO: begin
                                pre_q   <= 1'b0;
                                state_q <= pre_q ? S_MODE_RD_CLK : S_ERR_RD;
                            end
                            default: begin done_q <= 1'b1; state_q <= S_IDLE; end
                        endcase
                    end else if (try_last) begin
                        err_q   <= (poll_q == PK_USER) ? E_USER_TO : E_RDY_TO;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else state_q <= S_POLL_WAIT;
                end
                S_POLL_WAIT:     if (wait_done) state_q <= S_POLL_RD;
                S_PROG_RD_XFER:  if (reg_ack_i) state_q <= S_PROG_WR_XFER;
                S_PROG_WR_XFER:  if (reg_ack_i) state_q <= S_MODE_RD_RATIO;
                S_MODE_RD_RATIO: if (reg_ack_i) state_q <= S_MODE_WR_RATIO;
                S_MODE_WR_RATIO: if (reg_ack_i) state_q <= S_DATA_WAIT;
                S_DATA_WAIT: if (img_valid_i) begin
                    img_q <= img_data_i; last_q <= img_last_i; state_q <= S_DATA_WR;
                end
                S_DATA_WR:    if (reg_ack_i) state_q <= last_q ? S_TD_RD : S_DATA_WAIT;
                S_TD_RD:      if (reg_ack_i) state_q <= S_TD_WR_XFER;
                S_TD_WR_XFER: if (reg_ack_i) state_q <= S_TD_WR_CFG;
                S_TD_WR_CFG:  if (reg_ack_i) begin ret_q <= CR_TD; state_q <= S_CS_RD; end
                S_ERR_RD: if (reg_ack_i) begin
                    if (reg_rdata_i[UE_LATCH]) begin
                        err_q <= E_LATCHED; done_q <= 1'b1; state_q <= S_IDLE;
                    end else state_q <= S_MODE_RD_EXIT;
                end
                S_MODE_RD_EXIT: if (reg_ack_i) state_q <= S_MODE_WR_EXIT;
                S_MODE_WR_EXIT: if (reg_ack_i) begin poll_q <= PK_USER; state_q <= S_POLL_RD; end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b0;
        reg_addr_o  = A_STAT;
        reg_wdata_o = '0;
        img_ready_o = 1'b0;
        unique case (state_q)
            S_IDLE, S_POLL_WAIT: reg_req_o = 1'b0;
            S_DATA_WAIT: begin reg_req_o = 1'b0; img_ready_o = 1'b1; end
            S_STAT_RD, S_POLL_RD: reg_addr_o = A_STAT;
            S_MODE_RD_CLK, S_MODE_RD_CFG, S_CS_RD, S_MODE_RD_RATIO, S_MODE_RD_EXIT:
                reg_addr_o = A_MODE;
            S_PROG_RD_CFG, S_PROG_RD_XFER, S_TD_RD: reg_addr_o = A_PROG;
            S_ERR_RD: reg_addr_o = A_UERR;
            S_MODE_WR_CLK: begin
                reg_we_o = 1'b1; reg_addr_o = A_MODE;
                reg_wdata_o = rd_q | (32'd1 << MD_XCVR);
            end
            S_MODE_WR_CFG: begin
                reg_we_o = 1'b1; reg_addr_o = A_MODE;
                reg_wdata_o = rd_q | (32'd1 << MD_CFG);
            end
            S_CS_WR: begin
                reg_we_o = 1'b1; reg_addr_o = A_MODE;
                reg_wdata_o = {rd_q[31:16], 8'd1, rd_q[7:0]};
            end
            S_MODE_WR_RATIO: begin
                reg_we_o = 1'b1; reg_addr_o = A_MODE;
                reg_wdata_o = {rd_q[31:16], ratio_q, rd_q[7:0]};
            end
            S_MODE_WR_EXIT: begin
                reg_we_o = 1'b1; reg_addr_o = A_MODE;
                reg_wdata_o = rd_q & ~32'h3;
            end
            S_CS_DUMMY: begin reg_we_o = 1'b1; reg_addr_o = A_DATA; end
            S_DATA_WR: begin reg_we_o = 1'b1; reg_addr_o = A_DATA; reg_wdata_o = img_q; end
            S_PROG_WR_CFG: begin
                reg_we_o = 1'b1; reg_addr_o = A_PROG;
                reg_wdata_o = rd_q | (32'd1 << PG_CFG);
            end
            S_PROG_WR_XFER: begin
                reg_we_o = 1'b1; reg_addr_o = A_PROG;
                reg_wdata_o = rd_q | (32'd1 << PG_XFER);
            end
            S_TD_WR_XFER: begin
                reg_we_o = 1'b1; reg_addr_o = A_PROG;
                reg_wdata_o = rd_q & ~(32'd1 << PG_XFER);
            end
            S_TD_WR_CFG: begin
                reg_we_o = 1'b1; reg_addr_o = A_PROG;
                reg_wdata_o = rd_q & ~32'h3;
            end
            default: reg_req_o = 1'b0;
        endcase
    end

    assign busy_o = (state_q != S_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R8: a pending access keeps its address and data until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
                                        && $stable(reg_we_o) && $stable(reg_wdata_o)));
    // R8: no stream handshake while a register access is outstanding
    p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> !reg_req_o);
    // R4: the mode write that sets config mode already carries the clock select
    p_mode_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MODE_WR_CFG && reg_req_o) |-> reg_wdata_o[MD_XCVR]);
    // R11: a result code is visible only once the sequence has ended
    p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (err_o == 3'd0));
    // R1: completion is a single-cycle pulse issued from idle
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));
endmodule

// File: tb/cfg_load_seq_bench.sv
module cfg_load_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IVL        = 10;   // CLK_MHZ=1 * IVL_US=10
    localparam int RDY_N      = 4;    // ceil(35/10)
    localparam int USER_N     = 6;    // ceil(55/10)
    localparam int NDUMMY     = 244;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0, comp = 1'b0, enc = 1'b0;
    logic [31:0] img_data = '0;
    logic        img_valid = 1'b0, img_last = 1'b0, img_ready;
    logic        req, we, ack = 1'b0, busy, done;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata = '0;
    logic [2:0]  err;

    int tests = 0, fails = 0, cyc = 0;

    cfg_load_seq #(.CLK_MHZ(1), .IVL_US(10), .RDY_TO_US(35), .USER_TO_US(55),
                   .DUMMY_WRITES(NDUMMY)) u_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .compressed_i(comp),
        .encrypted_i(enc), .img_data_i(img_data), .img_valid_i(img_valid),
        .img_last_i(img_last), .img_ready_o(img_ready), .reg_req_o(req),
        .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
        .reg_rdata_i(rdata), .reg_ack_i(ack), .busy_o(busy), .done_o(done),
        .err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Device register model
    logic [31:0] dev_mode = '0, dev_prog = '0;
    bit k_en, k_rdy_low, k_rdy_high, k_latch, k_user;
    int lat = 0, gap_cnt = 0, stat_since = 0, stat_total = 0, last_stat = 0, min_gap = 1 << 30;
    int nlog = 0, nimg = 0, nexp = 0;
    logic [7:0]  l_addr [64];
    logic [31:0] l_data [64];
    int          l_gap  [64];
    logic [7:0]  e_addr [64];
    logic [31:0] e_data [64];
    int          e_gap  [64];
    logic [31:0] got_img [64];
    logic [31:0] img [64];

    function automatic logic [31:0] stat_val();
        logic rdy, usr;
        rdy = k_rdy_high ? 1'b1 : (k_rdy_low ? 1'b0 : dev_prog[0]);
        usr = k_user && (dev_mode[1:0] == 2'b00);
        return (32'(usr) << 24) | (32'(usr) << 21) | (32'(k_en) << 20) | (32'(rdy) << 18);
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) ack <= 1'b0;
        else begin
            ack <= 1'b0;
            if (req && !ack) begin
                if (lat == 0) begin
                    ack <= 1'b1;
                    lat = $urandom % 3;
                    if (we) begin
                        if (addr == 8'h28) begin
                            gap_cnt++;
                            if (dev_prog[1] && nimg < 64) begin got_img[nimg] = wdata; nimg++; end
                        end else begin
                            if (nlog < 64) begin
                                l_addr[nlog] = addr; l_data[nlog] = wdata; l_gap[nlog] = gap_cnt;
                            end
                            nlog++; gap_cnt = 0; stat_since = 0;
                            if (addr == 8'h20) dev_mode = wdata;
                            if (addr == 8'h2C) dev_prog = wdata;
                        end
                    end else begin
                        case (addr)
                            8'h1C: begin
                                rdata <= stat_val();
                                if (stat_since > 0 && cyc - last_stat < min_gap) min_gap = cyc - last_stat;
                                last_stat = cyc; stat_since++; stat_total++;
                            end
                            8'h20: rdata <= dev_mode;
                            8'h2C: rdata <= dev_prog;
                            8'h34: rdata <= 32'(k_latch) << 5;
                            default: rdata <= '0;
                        endcase
                    end
                end else lat = lat - 1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(bit ok, string req_tag, string what, longint act, longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_ratio(bit c, bit e);
        return c ? 8'd8 : (e ? 8'd4 : 8'd1);
    endfunction

    int pend;
    task automatic push(logic [7:0] a, logic [31:0] d, int next_gap);
        e_addr[nexp] = a; e_data[nexp] = d; e_gap[nexp] = pend; nexp++; pend = next_gap;
    endtask

    // Expected control-write order derived from R3, R4, R5, R7, R9, R10, R11
    task automatic build_exp(logic [31:0] m0, logic [31:0] p0, bit pre, logic [7:0] ratio,
                             int nw, bit with_exit);
        logic [31:0] m, p;
        m = m0; p = p0; nexp = 0; pend = 0;
        if (pre) begin
            p = p & ~32'h2; push(8'h2C, p, 0);
            p = p & ~32'h1; push(8'h2C, p, 0);
            m = {m[31:16], 8'd1, m[7:0]}; push(8'h20, m, NDUMMY);
        end
        m = m | 32'h2; push(8'h20, m, 0);
        m = m | 32'h1; push(8'h20, m, 0);
        m = {m[31:16], 8'd1, m[7:0]}; push(8'h20, m, NDUMMY);
        p = p | 32'h1; push(8'h2C, p, 0);
        m = {m[31:16], 8'd1, m[7:0]}; push(8'h20, m, NDUMMY);
        p = p | 32'h2; push(8'h2C, p, 0);
        m = {m[31:16], ratio, m[7:0]}; push(8'h20, m, nw);
        p = p & ~32'h2; push(8'h2C, p, 0);
        p = p & ~32'h1; push(8'h2C, p, 0);
        m = {m[31:16], 8'd1, m[7:0]}; push(8'h20, m, NDUMMY);
        if (with_exit) begin m = m & ~32'h3; push(8'h20, m, 0); end
    endtask

    task automatic cmp_seq(string tag);
        int bad;
        bad = -1;
        chk(nlog == nexp, tag, "control write count", nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            if (bad < 0 && (l_addr[i] !== e_addr[i] || l_data[i] !== e_data[i] || l_gap[i] != e_gap[i]))
                bad = i;
        if (bad >= 0) begin
            chk(l_data[bad] === e_data[bad], tag, $sformatf("write %0d data (addr %0h)", bad, l_addr[bad]),
                l_data[bad], e_data[bad]);
            chk(l_gap[bad] == e_gap[bad], tag, $sformatf("data writes before write %0d", bad),
                l_gap[bad], e_gap[bad]);
        end else chk(1'b1, tag, "control sequence", 0, 0);
    endtask

    bit run_over;
    task automatic run_load(bit en, bit rlow, bit rhigh, bit latch, bit usr, bit c, bit e,
                            int nw, logic [31:0] m0, logic [31:0] p0, bit gaps);
        int t;
        k_en = en; k_rdy_low = rlow; k_rdy_high = rhigh; k_latch = latch; k_user = usr;
        dev_mode = m0; dev_prog = p0;
        nlog = 0; nimg = 0; gap_cnt = 0; stat_since = 0; stat_total = 0; min_gap = 1 << 30;
        for (int i = 0; i < nw; i++) img[i] = $urandom;
        @(negedge clk); start = 1'b1; comp = c; enc = e;
        @(negedge clk); start = 1'b0;
        run_over = 1'b0;
        fork
            begin : stream
                int idx; bit took;
                idx = 0; took = 1'b0;
                while (!run_over) begin
                    @(negedge clk);
                    if (took) idx++;
                    if (idx < nw && (!gaps || ($urandom % 4) != 0)) begin
                        img_valid = 1'b1; img_data = img[idx]; img_last = (idx == nw - 1);
                    end else begin
                        img_valid = 1'b0; img_last = 1'b0;
                    end
                    took = img_valid && img_ready;
                end
                img_valid = 1'b0; img_last = 1'b0;
            end
            begin
                t = 0;
                do begin @(negedge clk); t++; end while (!done && t < 20000);
                chk(done == 1'b1, "R11", "load finished", t, 0);
                run_over = 1'b1;
            end
        join
    endtask

    task automatic check_ok(string tag, bit c, bit e, int nw, logic [31:0] m0, logic [31:0] p0, bit pre);
        int bad;
        chk(err == 3'd0, "R11", {tag, " result code"}, err, 0);
        chk(busy == 1'b0, "R11", {tag, " idle after done"}, busy, 0);
        build_exp(m0, p0, pre, exp_ratio(c, e), nw, 1'b1);
        cmp_seq(tag);
        chk(nimg == nw, "R8", {tag, " image words written"}, nimg, nw);
        bad = -1;
        for (int i = 0; i < nw && i < nimg; i++) if (bad < 0 && got_img[i] !== img[i]) bad = i;
        if (bad >= 0) chk(1'b0, "R8", {tag, " image word order"}, got_img[bad], img[bad]);
        else chk(1'b1, "R8", "", 0, 0);
        chk(gap_cnt == 0, "R5", {tag, " trailing data writes"}, gap_cnt, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(2024);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && req == 0 && img_ready == 0 && err == 0, "R1",
            "reset outputs", {busy, done, req, img_ready, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && req == 0, "R1", "idle after reset", {busy, req}, 0);

        // R2: enable flag clear
        run_load(0, 0, 0, 0, 1, 0, 0, 3, 32'h0, 32'h0, 0);
        chk(err == 3'd1, "R2", "not enabled code", err, 1);
        chk(nlog == 0 && gap_cnt == 0, "R2", "writes issued", nlog + gap_cnt, 0);

        // Directed success, plain image, no stream gaps (R4 R5 R7 R9 R11)
        run_load(1, 0, 0, 0, 1, 0, 0, 5, 32'hA5A5_0000, 32'h0, 0);
        check_ok("R4 R5 R9 plain", 0, 0, 5, 32'hA5A5_0000, 32'h0, 0);

        // R3: config-ready already set, teardown first
        run_load(1, 0, 0, 0, 1, 0, 1, 4, 32'h1234_5678 & 32'hFFFF_FFFC, 32'h3, 1);
        check_ok("R3 pre-teardown", 0, 1, 4, 32'h1234_5678 & 32'hFFFF_FFFC, 32'h3, 1);

        // R6: ready never rises; R12: poll spacing
        run_load(1, 1, 0, 0, 1, 0, 0, 2, 32'h0, 32'h0, 0);
        chk(err == 3'd2, "R6", "ready timeout code", err, 2);
        chk(stat_since == RDY_N, "R6", "ready poll reads", stat_since, RDY_N);
        chk(min_gap >= IVL, "R12", "status read spacing", min_gap, IVL);

        // R6: ready stuck high, pre-teardown poll for 0 times out
        run_load(1, 0, 1, 0, 1, 0, 0, 2, 32'h0, 32'h3, 0);
        chk(err == 3'd2, "R6", "teardown ready timeout code", err, 2);
        chk(stat_since == RDY_N, "R6", "teardown poll reads", stat_since, RDY_N);

        // R10: latched error
        run_load(1, 0, 0, 1, 1, 1, 0, 3, 32'h0, 32'h0, 1);
        chk(err == 3'd3, "R10", "latched error code", err, 3);
        build_exp(32'h0, 32'h0, 0, 8'd8, 3, 1'b0);
        cmp_seq("R10 no exit write");

        // R11: user mode never reported
        run_load(1, 0, 0, 0, 0, 0, 0, 3, 32'h0, 32'h0, 1);
        chk(err == 3'd4, "R11", "user-mode timeout code", err, 4);
        chk(stat_since == USER_N, "R11", "user poll reads", stat_since, USER_N);
        chk(min_gap >= IVL, "R12", "user poll spacing", min_gap, IVL);

        // R7: ratio for compressed+encrypted and encrypted-only
        run_load(1, 0, 0, 0, 1, 1, 1, 2, 32'h0, 32'h0, 1);
        check_ok("R7 compressed", 1, 1, 2, 32'h0, 32'h0, 0);
        run_load(1, 0, 0, 0, 1, 0, 1, 1, 32'h0, 32'h0, 1);
        check_ok("R7 encrypted", 0, 1, 1, 32'h0, 32'h0, 0);

        // Random loads (R7 R8)
        for (int r = 0; r < 8; r++) begin
            bit c, e; int nw; logic [31:0] m0;
            c = 1'($urandom); e = 1'($urandom); nw = 1 + $urandom % 20;
            m0 = $urandom & 32'hFFFF_FFFC;
            run_load(1, 0, 0, 0, 1, c, e, nw, m0, 32'h0, 1);
            check_ok("R7 R8 random", c, e, nw, m0, 32'h0, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule